// File: doc/BRIEF.md
# Display Timing Generator with Frame-Boundary Register Commit

This block drives a progressive panel. It produces horizontal sync, vertical sync, data-enable and the active pixel coordinates from programmable porch, sync-width and active-size values. Software writes the timing through a single-cycle register write port. Each write lands in a shadow copy. While the generator runs, the shadow set reaches the live counters only on the last pixel of a frame. A frame can therefore never be built from half-old and half-new timing.

The block passes upstream pixels through while data-enable is high. If the upstream source has no valid pixel during active video, the block sends zero for that pixel and records an underflow. The block keeps two sticky events: frame end and underflow. Each event has its own mask. A masked event drives the interrupt line. Software clears an event by writing a one to its bit. A global run bit stops the timing. A separate bit gates the outgoing pixel clock enable.

Top module: `dtg_top`

## Requirements
- R1: After reset the generator is stopped, all timing fields and interrupt state are zero, de and coordinates are zero, and hsync and vsync sit at their inactive level.
- R2: Each line is a sequence of sync (field+1 cycles), back porch, active (width field+1 cycles) and front porch, with hsync active only during the first phase. The horizontal porch register (address 0) holds front porch in bits [CW-1:0] and back porch in bits [2CW-1:CW]. The sync-width register (address 2) holds width minus one.
- R3: Each frame is a sequence of vsync lines, back-porch lines, active lines (height field+1) and front-porch lines. The vertical porch register is address 1 and uses the same layout as the horizontal one. The vertical sync register is address 3 and holds width minus one.
- R4: A vertical sync write above 14 is stored as 14, so vsync lasts at most 15 lines.
- R5: de is high only where horizontal and vertical active regions overlap. pix_x and pix_y count from 0 inside that region and are 0 outside it. The size register (address 4) holds width minus one in [CW-1:0] and height minus one in [2CW-1:CW].
- R6: The control register is address 5. Bit 1 inverts hsync and bit 2 inverts vsync, so a set bit gives active-low sync.
- R7: While running, timing written to addresses 0 to 4 takes effect only after the frame-end cycle. While stopped, it takes effect on the second cycle after the write.
- R8: Frame end is the last cycle of the last front-porch line. It sets sticky status bit 0 on the following cycle.
- R9: A cycle with de high and pix_valid low drives pix_out to zero and sets sticky status bit 1. Otherwise pix_out equals pix_in when de is high and zero when de is low.
- R10: The mask register is address 6, with bit 0 for frame end and bit 1 for underflow. irq_status is the sticky status ANDed with the mask, and irq is high when any bit of irq_status is high.
- R11: Writing a one to a bit of address 7 clears that sticky bit on the next cycle. If a new event arrives in the same cycle as the clear, the event wins.
- R12: Control bit 0 is the run bit. Clearing it returns the outputs to idle and the counters to the start of a frame, and the next run starts at pixel 0 of line 0. Control bit 3 drives pix_clk_en directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 2*CW | Register write data |
| pix_valid | input | 1 | Upstream pixel available |
| pix_in | input | PW | Upstream pixel |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable |
| pix_x | output | CW | Active column |
| pix_y | output | CW | Active row |
| pix_out | output | PW | Pixel to panel, zero on underflow |
| pix_clk_en | output | 1 | Outgoing pixel clock enable |
| irq | output | 1 | Interrupt request |
| irq_status | output | 2 | Masked sticky status (bit 0 frame end, bit 1 underflow) |

## Verification
A wrong horizontal count shows on hsync or de within one line. A wrong vertical count shows on vsync within one frame. A commit at the wrong moment changes the line length before the frame boundary, so the first line after a mid-frame write already disagrees with the scoreboard. Wrong sticky, mask or clear state shows on irq_status and irq one cycle after the event or write that caused it. A stuck run bit or a wrong idle level shows on the first cycle after the control write.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_HPORCH = 3'd0;
   localparam logic [ADDR_W-1:0] A_VPORCH = 3'd1;
   localparam logic [ADDR_W-1:0] A_HSYNC  = 3'd2;
   localparam logic [ADDR_W-1:0] A_VSYNC  = 3'd3;
   localparam logic [ADDR_W-1:0] A_SIZE   = 3'd4;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;
   localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd6;
   localparam logic [ADDR_W-1:0] A_IRQCLR = 3'd7;

   localparam int C_RUN  = 0;
   localparam int C_HINV = 1;
   localparam int C_VINV = 2;
   localparam int C_PCLK = 3;

   localparam int N_IRQ  = 2;
   localparam int IRQ_FE = 0;
   localparam int IRQ_UF = 1;

   localparam int AX_H = 0;
   localparam int AX_V = 1;
   localparam int N_AX = 2;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int CW      = 12,
   parameter int VSW_MAX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2*CW-1:0]   wr_data,
   input  logic              commit,
   output logic [CW-1:0]     l_hfp,
   output logic [CW-1:0]     l_hbp,
   output logic [CW-1:0]     l_hsw,
   output logic [CW-1:0]     l_vfp,
   output logic [CW-1:0]     l_vbp,
   output logic [CW-1:0]     l_vsw,
   output logic [CW-1:0]     l_wm1,
   output logic [CW-1:0]     l_hm1,
   output logic              run,
   output logic              hinv,
   output logic              vinv,
   output logic              pclk_on,
   output logic [N_IRQ-1:0]  irq_en,
   output logic [N_IRQ-1:0]  irq_clr
);
   localparam logic [CW-1:0] VSW_M1_MAX = CW'(VSW_MAX - 1);

   generate
      if (VSW_MAX < 1 || VSW_MAX > (1 << CW)) begin : g_bad_vsw
         $error("dtg_regs: VSW_MAX out of range");
      end
   endgenerate

   logic [CW-1:0] lo, hi;
   assign lo = wr_data[CW-1:0];
   assign hi = wr_data[2*CW-1:CW];

   logic [CW-1:0] s_hfp, s_hbp, s_hsw, s_vfp, s_vbp, s_vsw, s_wm1, s_hm1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_hfp <= '0; s_hbp <= '0; s_hsw <= '0; s_vfp <= '0;
         s_vbp <= '0; s_vsw <= '0; s_wm1 <= '0; s_hm1 <= '0;
         run <= 1'b0; hinv <= 1'b0; vinv <= 1'b0; pclk_on <= 1'b0;
         irq_en <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_HPORCH: begin s_hfp <= lo; s_hbp <= hi; end
            A_VPORCH: begin s_vfp <= lo; s_vbp <= hi; end
            A_HSYNC:  s_hsw <= lo;
            A_VSYNC:  s_vsw <= (lo > VSW_M1_MAX) ? VSW_M1_MAX : lo;
            A_SIZE:   begin s_wm1 <= lo; s_hm1 <= hi; end
            A_CTRL: begin
               run     <= lo[C_RUN];
               hinv    <= lo[C_HINV];
               vinv    <= lo[C_VINV];
               pclk_on <= lo[C_PCLK];
            end
            A_IRQEN:  irq_en <= lo[N_IRQ-1:0];
            default:  ;
         endcase
      end
   end

   assign irq_clr = (wr_en && wr_addr == A_IRQCLR) ? lo[N_IRQ-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_hfp <= '0; l_hbp <= '0; l_hsw <= '0; l_vfp <= '0;
         l_vbp <= '0; l_vsw <= '0; l_wm1 <= '0; l_hm1 <= '0;
      end else if (commit) begin
         l_hfp <= s_hfp; l_hbp <= s_hbp; l_hsw <= s_hsw; l_vfp <= s_vfp;
         l_vbp <= s_vbp; l_vsw <= s_vsw; l_wm1 <= s_wm1; l_hm1 <= s_hm1;
      end
   end

   p_vsw_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      l_vsw <= VSW_M1_MAX);
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [CW-1:0] sync_m1,
   input  logic [CW-1:0] bp,
   input  logic [CW-1:0] act_m1,
   input  logic [CW-1:0] fp,
   output logic          sync_act,
   output logic          act,
   output logic [CW-1:0] pos,
   output logic          last
);
   localparam int TW = CW + 2;

   logic [TW-1:0] cnt, a0, a1, tot, diff;

   assign a0   = TW'(sync_m1) + TW'(1) + TW'(bp);
   assign a1   = a0 + TW'(act_m1) + TW'(1);
   assign tot  = a1 + TW'(fp);
   assign last = (cnt == tot - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (step)   cnt <= last ? '0 : cnt + TW'(1);
   end

   assign sync_act = run && (cnt <= TW'(sync_m1));
   assign act      = run && (cnt >= a0) && (cnt < a1);
   assign diff     = cnt - a0;
   assign pos      = act ? diff[CW-1:0] : '0;

   logic unused_diff;
   assign unused_diff = ^diff[TW-1:CW];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < tot);
   p_sync_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_act |-> !act);
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] raw,
   output logic [N-1:0] masked,
   output logic         irq
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dtg_irq: N must be at least 1");
      end
      for (genvar b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      raw[b] <= 1'b0;
            else if (set[b]) raw[b] <= 1'b1;
            else if (clr[b]) raw[b] <= 1'b0;
         end

         p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[b] && !set[b]) |=> !raw[b]);
         p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set[b] |=> raw[b]);
      end
   endgenerate

   assign masked = raw & en;
   assign irq    = |masked;
endmodule

// File: rtl/dtg_top.sv
module dtg_top
   import dtg_pkg::*;
#(
   parameter int CW      = 12,
   parameter int PW      = 24,
   parameter int VSW_MAX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [2*CW-1:0]   wr_data,
   input  logic              pix_valid,
   input  logic [PW-1:0]     pix_in,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CW-1:0]     pix_x,
   output logic [CW-1:0]     pix_y,
   output logic [PW-1:0]     pix_out,
   output logic              pix_clk_en,
   output logic              irq,
   output logic [N_IRQ-1:0]  irq_status
);
   generate
      if (CW < 4 || CW > 16) begin : g_bad_cw
         $error("dtg_top: CW must lie in 4..16");
      end
      if (PW < 1) begin : g_bad_pw
         $error("dtg_top: PW must be positive");
      end
   endgenerate

   logic [CW-1:0] l_hfp, l_hbp, l_hsw, l_vfp, l_vbp, l_vsw, l_wm1, l_hm1;
   logic          run, hinv, vinv, pclk_on, frame_end, commit;
   logic [N_IRQ-1:0] irq_en, irq_clr, ev_set, st_raw;

   assign commit = frame_end || !run;

   dtg_regs #(.CW(CW), .VSW_MAX(VSW_MAX)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .commit(commit),
      .l_hfp(l_hfp), .l_hbp(l_hbp), .l_hsw(l_hsw), .l_vfp(l_vfp),
      .l_vbp(l_vbp), .l_vsw(l_vsw), .l_wm1(l_wm1), .l_hm1(l_hm1),
      .run(run), .hinv(hinv), .vinv(vinv), .pclk_on(pclk_on),
      .irq_en(irq_en), .irq_clr(irq_clr)
   );

   logic [CW-1:0] ax_sync [N_AX];
   logic [CW-1:0] ax_bp   [N_AX];
   logic [CW-1:0] ax_act  [N_AX];
   logic [CW-1:0] ax_fp   [N_AX];
   logic [CW-1:0] ax_pos  [N_AX];
   logic [N_AX-1:0] ax_step, ax_sact, ax_in, ax_last;

   assign ax_sync[AX_H] = l_hsw; assign ax_bp[AX_H] = l_hbp;
   assign ax_act[AX_H]  = l_wm1; assign ax_fp[AX_H] = l_hfp;
   assign ax_sync[AX_V] = l_vsw; assign ax_bp[AX_V] = l_vbp;
   assign ax_act[AX_V]  = l_hm1; assign ax_fp[AX_V] = l_vfp;
   assign ax_step[AX_H] = 1'b1;
   assign ax_step[AX_V] = ax_last[AX_H];

   generate
      for (genvar a = 0; a < N_AX; a++) begin : g_axis
         dtg_axis #(.CW(CW)) u_axis (
            .clk(clk), .rst_n(rst_n), .run(run), .step(ax_step[a]),
            .sync_m1(ax_sync[a]), .bp(ax_bp[a]), .act_m1(ax_act[a]),
            .fp(ax_fp[a]), .sync_act(ax_sact[a]), .act(ax_in[a]),
            .pos(ax_pos[a]), .last(ax_last[a])
         );
      end
   endgenerate

   assign frame_end  = run && ax_last[AX_H] && ax_last[AX_V];
   assign de         = ax_in[AX_H] && ax_in[AX_V];
   assign pix_x      = de ? ax_pos[AX_H] : '0;
   assign pix_y      = de ? ax_pos[AX_V] : '0;
   assign hsync      = ax_sact[AX_H] ^ hinv;
   assign vsync      = ax_sact[AX_V] ^ vinv;
   assign pix_out    = (de && pix_valid) ? pix_in : '0;
   assign pix_clk_en = pclk_on;

   assign ev_set[IRQ_FE] = frame_end;
   assign ev_set[IRQ_UF] = de && !pix_valid;

   dtg_irq #(.N(N_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(irq_clr), .en(irq_en),
      .raw(st_raw), .masked(irq_status), .irq(irq)
   );

   p_fe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> st_raw[IRQ_FE]);
   p_uf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (de && !pix_valid) |=> st_raw[IRQ_UF]);
   p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> ($stable(l_wm1) && $stable(l_hfp) && $stable(l_vsw)));
   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq);
   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!de && !frame_end && pix_x == '0 && pix_y == '0));
endmodule

// File: tb/dtg_top_tb_top.sv
module dtg_top_tb_top;
   localparam int CW = 12;
   localparam int PW = 24;
   localparam int DW = 2 * CW;
   localparam int MSK = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic pix_valid = 1'b1;
   logic [PW-1:0] pix_in = '0;
   logic hsync, vsync, de, pix_clk_en, irq;
   logic [CW-1:0] pix_x, pix_y;
   logic [PW-1:0] pix_out;
   logic [1:0] irq_status;

   always #5 clk = ~clk;

   dtg_top #(.CW(CW), .PW(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pix_valid(pix_valid), .pix_in(pix_in),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .pix_out(pix_out), .pix_clk_en(pix_clk_en), .irq(irq),
      .irq_status(irq_status)
   );

   typedef struct {
      string tag;
      logic hs, vs, de, irq, pce;
      int x, y;
      logic [PW-1:0] pix;
      logic [1:0] ist;
   } exp_t;

   exp_t q[$];
   int vectors = 0;
   int miscompares = 0;
   bit done = 0;
   string phase = "R1";

   // reference model state
   int sh_hfp, sh_hbp, sh_hsw, sh_vfp, sh_vbp, sh_vsw, sh_wm1, sh_hm1;
   int lv_hfp, lv_hbp, lv_hsw, lv_vfp, lv_vbp, lv_vsw, lv_wm1, lv_hm1;
   int mh, mv;
   bit m_en, m_hinv, m_vinv, m_pce;
   bit [1:0] m_ien, m_st;
   int seed = 1;

   task automatic model_reset();
      sh_hfp = 0; sh_hbp = 0; sh_hsw = 0; sh_vfp = 0;
      sh_vbp = 0; sh_vsw = 0; sh_wm1 = 0; sh_hm1 = 0;
      lv_hfp = 0; lv_hbp = 0; lv_hsw = 0; lv_vfp = 0;
      lv_vbp = 0; lv_vsw = 0; lv_wm1 = 0; lv_hm1 = 0;
      mh = 0; mv = 0; m_en = 0; m_hinv = 0; m_vinv = 0; m_pce = 0;
      m_ien = 0; m_st = 0;
   endtask

   task automatic tick(input bit we, input int a, input int d, input bit valid);
      exp_t e;
      int hs0, ha1, ht, vs0, va1, vt;
      bit fe, uf, hl;
      bit [1:0] clr;
      @(negedge clk);
      wr_en = we; wr_addr = 3'(a); wr_data = DW'(d);
      pix_valid = valid; pix_in = PW'(seed * 40503); seed++;
      hs0 = lv_hsw + 1 + lv_hbp; ha1 = hs0 + lv_wm1 + 1; ht = ha1 + lv_hfp;
      vs0 = lv_vsw + 1 + lv_vbp; va1 = vs0 + lv_hm1 + 1; vt = va1 + lv_vfp;
      e.tag = phase;
      e.hs  = (m_en && mh <= lv_hsw) ^ m_hinv;
      e.vs  = (m_en && mv <= lv_vsw) ^ m_vinv;
      e.de  = m_en && mh >= hs0 && mh < ha1 && mv >= vs0 && mv < va1;
      e.x   = e.de ? mh - hs0 : 0;
      e.y   = e.de ? mv - vs0 : 0;
      e.pix = (e.de && valid) ? pix_in : '0;
      e.ist = m_st & m_ien;
      e.irq = |(m_st & m_ien);
      e.pce = m_pce;
      q.push_back(e);
      // next state
      hl  = (mh == ht - 1);
      fe  = m_en && hl && (mv == vt - 1);
      uf  = e.de && !valid;
      clr = (we && a == 7) ? 2'(d) : 2'b00;
      m_st[0] = fe | (m_st[0] & ~clr[0]);
      m_st[1] = uf | (m_st[1] & ~clr[1]);
      if (!m_en) begin mh = 0; mv = 0; end
      else if (hl) begin mh = 0; mv = (mv == vt - 1) ? 0 : mv + 1; end
      else mh = mh + 1;
      if (fe || !m_en) begin
         lv_hfp = sh_hfp; lv_hbp = sh_hbp; lv_hsw = sh_hsw; lv_vfp = sh_vfp;
         lv_vbp = sh_vbp; lv_vsw = sh_vsw; lv_wm1 = sh_wm1; lv_hm1 = sh_hm1;
      end
      if (we) begin
         case (a)
            0: begin sh_hfp = d & MSK; sh_hbp = (d >> CW) & MSK; end
            1: begin sh_vfp = d & MSK; sh_vbp = (d >> CW) & MSK; end
            2: sh_hsw = d & MSK;
            3: sh_vsw = ((d & MSK) > 14) ? 14 : (d & MSK);
            4: begin sh_wm1 = d & MSK; sh_hm1 = (d >> CW) & MSK; end
            5: begin m_en = d[0]; m_hinv = d[1]; m_vinv = d[2]; m_pce = d[3]; end
            6: m_ien = 2'(d);
            default: ;
         endcase
      end
   endtask

   task automatic wr(input int a, input int d);
      tick(1, a, d, 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 1);
   endtask

   task automatic fail_line(input string tag, input string f, input int act, input int exp);
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
   endtask

   // monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin
      exp_t e;
      bit bad;
      #1;
      if (q.size() > 0 && !done) begin
         e = q.pop_front();
         bad = 0;
         vectors++;
         if (hsync !== e.hs) begin bad = 1; fail_line(e.tag, "hsync", hsync, e.hs); end
         if (vsync !== e.vs) begin bad = 1; fail_line(e.tag, "vsync", vsync, e.vs); end
         if (de !== e.de) begin bad = 1; fail_line(e.tag, "de", de, e.de); end
         if (pix_x !== CW'(e.x)) begin bad = 1; fail_line(e.tag, "pix_x", pix_x, e.x); end
         if (pix_y !== CW'(e.y)) begin bad = 1; fail_line(e.tag, "pix_y", pix_y, e.y); end
         if (pix_out !== e.pix) begin bad = 1; fail_line(e.tag, "pix_out", pix_out, e.pix); end
         if (irq_status !== e.ist) begin bad = 1; fail_line(e.tag, "irq_status", irq_status, e.ist); end
         if (irq !== e.irq) begin bad = 1; fail_line(e.tag, "irq", irq, e.irq); end
         if (pix_clk_en !== e.pce) begin bad = 1; fail_line(e.tag, "pix_clk_en", pix_clk_en, e.pce); end
         if (bad) miscompares++;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle state after reset
      phase = "R1";
      idle(4);
      // R2 / R3 / R5: program geometry while stopped, then run
      phase = "R2";
      wr(0, (3 << CW) | 2);
      wr(1, (1 << CW) | 2);
      wr(2, 1);
      wr(3, 1);
      wr(4, (3 << CW) | 5);
      idle(2);
      wr(5, 'h9);
      idle(140);
      phase = "R3";
      idle(60);
      phase = "R5";
      idle(130);
      // R7: mid-frame change only commits at frame end
      phase = "R7";
      wr(0, (3 << CW) | 4);
      wr(4, (3 << CW) | 3);
      idle(260);
      // R8 / R10 / R11: frame-end event, mask and clear
      phase = "R8";
      wr(6, 1);
      idle(150);
      phase = "R11";
      wr(7, 1);
      idle(5);
      phase = "R10";
      wr(6, 0);
      idle(20);
      // R9: underflow during active video
      phase = "R9";
      wr(6, 3);
      for (int i = 0; i < 150; i++) tick(0, 0, 0, (i % 5) != 0);
      phase = "R11";
      for (int i = 0; i < 20; i++) tick(i == 10, 7, 3, (i % 3) != 0);
      wr(7, 3);
      idle(6);
      // R6: inverted sync polarity
      phase = "R6";
      wr(5, 'hF);
      idle(140);
      // R4: vertical sync width clamped to 15 lines
      phase = "R4";
      wr(5, 'h9);
      wr(3, 19);
      idle(600);
      // R12: stop, clock gate off, restart from the frame origin
      phase = "R12";
      wr(5, 0);
      idle(10);
      wr(5, 'h1);
      idle(40);
      @(negedge clk);
      #3;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule